// File: doc/BRIEF.md
# Target Write Admission and Error Lockout Controller

This block sits beside the receive path of a serial-bus target and rules on every write that the controller on the bus addresses to it. When a write begins, it compares the free room in the receive FIFO against a programmable start threshold. It also checks whether the response queue can take the first response, and whether an earlier error has locked the target. From these it answers with a one-cycle ACK or NACK pulse. During an accepted write it watches each received byte and each response push. An overflow of the data FIFO or of the response queue, or a parity error, raises a sticky error flag. The rest of the transfer is then discarded until STOP or RESTART.

Sticky errors put the target into a lockout. While it lasts, private writes and directed vendor-specific command writes are refused. The lockout ends only when the controller has read the target status and software has afterwards pulsed resume. A refusal caused by lack of receive room raises a buffer-not-available flag, which drops again by itself once room returns. Broadcast commands cannot be refused. When there is no room for one, it is still acknowledged but its data is marked as not forwarded. A receive DMA request is raised from the FIFO fill level when DMA mode is on.

The transfer state machine has four states. `XS_IDLE` waits for a start. `XS_RECV` forwards data of an accepted write. `XS_DROP` discards data after an error. `XS_IGNORE` covers a refused write or an unforwarded broadcast. Its transitions are: start-accept (IDLE to RECV), start-refuse (IDLE to IGNORE), error-hit (RECV to DROP), and terminate (RECV, DROP or IGNORE to IDLE). The lockout state machine has three states. `LK_CLEAR` means no error. `LK_WAIT_READ` means an error is held and the status read is awaited. `LK_WAIT_RESUME` means the status has been read and resume is awaited. Its transitions are: error-set (any state to WAIT_READ), status-seen (WAIT_READ to WAIT_RESUME), and resume-done (WAIT_RESUME to CLEAR).

Top module: `twa_ctrl`

## Requirements
- R1: A start is taken only in the idle state, and the transfer type is encoded as 0 private, 1 directed vendor command, 2 broadcast command, 3 treated as private. For types other than broadcast, `ack_o` pulses for one cycle in the cycle after the start when `rx_free_i >= start_thld_i`, `rspq_full_i` is low and no error flag is set. Otherwise `nack_o` pulses in that cycle instead, `drop_o` is high from that cycle until the cycle after `xfer_end_i`, and `ack_o` and `nack_o` are never high together.
- R2: A valid byte in an accepted transfer while `rx_free_i` is 0 sets `ovf_err_o` in the next cycle. `drop_o` is then high from that cycle until the cycle after `xfer_end_i`.
- R3: A valid byte with `parity_err_i` high in an accepted transfer sets `proto_err_o` in the next cycle and discards the rest of the transfer in the same way.
- R4: A response push (`rsp_push_i`) in an accepted transfer while `rspq_full_i` is high sets `ovf_err_o` and discards the rest of the transfer, exactly as a data overflow does.
- R5: While `ovf_err_o` or `proto_err_o` is set, every private or directed vendor command start is answered with `nack_o`.
- R6: Both error flags are sticky. A `resume_i` pulse clears them only if a `status_rd_i` pulse has come after the latest error. A resume without such a read leaves the flags and the lockout unchanged.
- R7: A refused private or directed start with `rx_free_i < start_thld_i` sets `buf_na_o` in the cycle of the NACK. `buf_na_o` clears in the cycle after `rx_free_i >= start_thld_i` is seen, with no software action.
- R8: A broadcast start is always answered with `ack_o`, whatever the lockout state. If room is short (free below threshold, or response queue full), `drop_o` is high for that transfer and `buf_na_o` is not set.
- R9: `rx_dma_req_o` is high, in the same cycle, exactly when `dma_en_i` is high and `rx_level_i >= rxbuf_thld_i`.
- R10: When a byte is both a parity error and an overflow, both flags are set, and a single read followed by a resume clears both.
- R11: After reset, `ack_o`, `nack_o`, `drop_o`, `ovf_err_o`, `proto_err_o` and `buf_na_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| xfer_start_i | input | 1 | A write addressed to this target begins |
| xfer_kind_i | input | 2 | Transfer type: 0 private, 1 directed vendor command, 2 broadcast command |
| byte_vld_i | input | 1 | A data byte is received this cycle |
| parity_err_i | input | 1 | The byte on `byte_vld_i` failed parity |
| rsp_push_i | input | 1 | A response must be written to the response queue |
| xfer_end_i | input | 1 | STOP or RESTART seen |
| rx_free_i | input | CNT_W | Empty locations in the receive FIFO |
| rx_level_i | input | CNT_W | Filled locations in the receive FIFO |
| rspq_full_i | input | 1 | Response queue is full |
| start_thld_i | input | CNT_W | Minimum free room needed to accept a write |
| rxbuf_thld_i | input | CNT_W | Fill level that raises the DMA request |
| dma_en_i | input | 1 | DMA mode enabled |
| status_rd_i | input | 1 | Controller has read the target status |
| resume_i | input | 1 | Software resume pulse |
| ack_o | output | 1 | Write accepted (one-cycle pulse) |
| nack_o | output | 1 | Write refused (one-cycle pulse) |
| drop_o | output | 1 | Incoming data of the current transfer is discarded |
| ovf_err_o | output | 1 | Sticky overflow error |
| proto_err_o | output | 1 | Sticky parity/protocol error |
| buf_na_o | output | 1 | Receive room below start threshold after a refusal |
| rx_dma_req_o | output | 1 | Receive DMA request |

## Verification
The bench builds the block with an eight-entry FIFO, giving four-bit counts. With that size, free room can be driven across the start threshold and down to zero, and the fill level across the DMA threshold, using small values near the boundaries. The start threshold is held at 4, so a free count of 3 against 4 shows the refusal edge and 0 shows the overflow edge. The lockout sequences are driven in both orders: resume before the read, and a fresh error arriving between the read and the resume.

// File: rtl/twa_pkg.sv
package twa_pkg;

    typedef enum logic [1:0] {
        KIND_PRIV  = 2'd0,
        KIND_DVCCC = 2'd1,
        KIND_BCAST = 2'd2,
        KIND_RSVD  = 2'd3
    } xfer_kind_e;

    typedef enum logic [1:0] {
        XS_IDLE   = 2'd0,
        XS_RECV   = 2'd1,
        XS_DROP   = 2'd2,
        XS_IGNORE = 2'd3
    } xfer_state_e;

    typedef enum logic [1:0] {
        LK_CLEAR       = 2'd0,
        LK_WAIT_READ   = 2'd1,
        LK_WAIT_RESUME = 2'd2
    } lock_state_e;

endpackage

// File: rtl/twa_admit.sv
module twa_admit #(
    parameter int CNT_W = 5
) (
    input  logic [1:0]       kind_i,
    input  logic [CNT_W-1:0] rx_free_i,
    input  logic [CNT_W-1:0] start_thld_i,
    input  logic             rspq_full_i,
    input  logic             locked_i,
    output logic             is_bcast_o,
    output logic             space_ok_o,
    output logic             room_ok_o,
    output logic             accept_o
);
    import twa_pkg::*;

    always_comb begin
        is_bcast_o = (kind_i == KIND_BCAST);
        space_ok_o = (rx_free_i >= start_thld_i);
        room_ok_o  = space_ok_o && !rspq_full_i;
        // broadcast cannot be refused; others need room and no lockout
        accept_o   = is_bcast_o || (room_ok_o && !locked_i);
    end

endmodule

// File: rtl/twa_xfer.sv
module twa_xfer #(
    parameter int CNT_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             is_bcast_i,
    input  logic             space_ok_i,
    input  logic             room_ok_i,
    input  logic             accept_i,
    input  logic             locked_i,
    input  logic             byte_vld_i,
    input  logic             parity_err_i,
    input  logic             rsp_push_i,
    input  logic             rspq_full_i,
    input  logic             end_i,
    input  logic [CNT_W-1:0] rx_free_i,
    output logic             ack_o,
    output logic             nack_o,
    output logic             drop_o,
    output logic             ovf_evt_o,
    output logic             proto_evt_o,
    output logic             bna_set_o
);
    import twa_pkg::*;

    xfer_state_e state_q, state_d;
    logic        ack_d, nack_d;
    logic        in_recv;
    logic        take_start;

    always_comb begin
        in_recv     = (state_q == XS_RECV);
        take_start  = (state_q == XS_IDLE) && start_i;
        proto_evt_o = in_recv && byte_vld_i && parity_err_i;
        ovf_evt_o   = in_recv && ((byte_vld_i && (rx_free_i == '0)) ||
                                  (rsp_push_i && rspq_full_i));
        bna_set_o   = take_start && !is_bcast_i && !space_ok_i;
    end

    // next state and decision
    always_comb begin
        state_d = state_q;
        ack_d   = 1'b0;
        nack_d  = 1'b0;
        unique case (state_q)
            XS_IDLE: begin
                if (start_i) begin
                    ack_d   = accept_i;
                    nack_d  = !accept_i;
                    state_d = (accept_i && room_ok_i && (is_bcast_i || !locked_i))
                              ? XS_RECV : XS_IGNORE;
                end
            end
            XS_RECV: begin
                if (end_i)
                    state_d = XS_IDLE;
                else if (ovf_evt_o || proto_evt_o)
                    state_d = XS_DROP;
            end
            XS_DROP, XS_IGNORE: begin
                if (end_i)
                    state_d = XS_IDLE;
            end
            default: state_d = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= XS_IDLE;
            ack_o   <= 1'b0;
            nack_o  <= 1'b0;
        end else begin
            state_q <= state_d;
            ack_o   <= ack_d;
            nack_o  <= nack_d;
        end
    end

    always_comb begin
        drop_o = (state_q == XS_DROP) || (state_q == XS_IGNORE);
    end

    p_ack_nack_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ack_o && nack_o));

    p_lock_nack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_start && !is_bcast_i && locked_i) |=> nack_o);

    p_bcast_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_start && is_bcast_i) |=> ack_o);

    p_drop_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == XS_DROP && !end_i) |=> drop_o);

endmodule

// File: rtl/twa_lock.sv
module twa_lock (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ovf_evt_i,
    input  logic proto_evt_i,
    input  logic bna_set_i,
    input  logic space_ok_i,
    input  logic status_rd_i,
    input  logic resume_i,
    output logic ovf_o,
    output logic proto_o,
    output logic buf_na_o,
    output logic locked_o
);
    import twa_pkg::*;

    lock_state_e lk_q, lk_d;
    logic        clr;
    logic        ovf_d, proto_d, bna_d;

    always_comb begin
        clr     = (lk_q == LK_WAIT_RESUME) && resume_i;
        lk_d    = lk_q;
        unique case (lk_q)
            LK_CLEAR:       ;
            LK_WAIT_READ:   if (status_rd_i) lk_d = LK_WAIT_RESUME;
            LK_WAIT_RESUME: if (resume_i)    lk_d = LK_CLEAR;
            default:        lk_d = LK_CLEAR;
        endcase
        // a fresh error always re-arms the read-then-resume sequence
        if (ovf_evt_i || proto_evt_i)
            lk_d = LK_WAIT_READ;
        ovf_d   = (ovf_o   && !clr) || ovf_evt_i;
        proto_d = (proto_o && !clr) || proto_evt_i;
        bna_d   = bna_set_i || (buf_na_o && !space_ok_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lk_q     <= LK_CLEAR;
            ovf_o    <= 1'b0;
            proto_o  <= 1'b0;
            buf_na_o <= 1'b0;
        end else begin
            lk_q     <= lk_d;
            ovf_o    <= ovf_d;
            proto_o  <= proto_d;
            buf_na_o <= bna_d;
        end
    end

    always_comb locked_o = ovf_o || proto_o;

    p_ovf_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_o && !(lk_q == LK_WAIT_RESUME && resume_i)) |=> ovf_o);

    p_resume_needs_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lk_q == LK_WAIT_READ && resume_i) |=> (ovf_o || proto_o));

    p_bna_autoclear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (buf_na_o && space_ok_i && !bna_set_i) |=> !buf_na_o);

endmodule

// File: rtl/twa_ctrl.sv
module twa_ctrl #(
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             xfer_start_i,
    input  logic [1:0]       xfer_kind_i,
    input  logic             byte_vld_i,
    input  logic             parity_err_i,
    input  logic             rsp_push_i,
    input  logic             xfer_end_i,
    input  logic [CNT_W-1:0] rx_free_i,
    input  logic [CNT_W-1:0] rx_level_i,
    input  logic             rspq_full_i,
    input  logic [CNT_W-1:0] start_thld_i,
    input  logic [CNT_W-1:0] rxbuf_thld_i,
    input  logic             dma_en_i,
    input  logic             status_rd_i,
    input  logic             resume_i,
    output logic             ack_o,
    output logic             nack_o,
    output logic             drop_o,
    output logic             ovf_err_o,
    output logic             proto_err_o,
    output logic             buf_na_o,
    output logic             rx_dma_req_o
);
    logic is_bcast, space_ok, room_ok, accept, locked;
    logic ovf_evt, proto_evt, bna_set;

    twa_admit #(.CNT_W(CNT_W)) u_admit (
        .kind_i       (xfer_kind_i),
        .rx_free_i    (rx_free_i),
        .start_thld_i (start_thld_i),
        .rspq_full_i  (rspq_full_i),
        .locked_i     (locked),
        .is_bcast_o   (is_bcast),
        .space_ok_o   (space_ok),
        .room_ok_o    (room_ok),
        .accept_o     (accept)
    );

    twa_xfer #(.CNT_W(CNT_W)) u_xfer (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (xfer_start_i),
        .is_bcast_i   (is_bcast),
        .space_ok_i   (space_ok),
        .room_ok_i    (room_ok),
        .accept_i     (accept),
        .locked_i     (locked),
        .byte_vld_i   (byte_vld_i),
        .parity_err_i (parity_err_i),
        .rsp_push_i   (rsp_push_i),
        .rspq_full_i  (rspq_full_i),
        .end_i        (xfer_end_i),
        .rx_free_i    (rx_free_i),
        .ack_o        (ack_o),
        .nack_o       (nack_o),
        .drop_o       (drop_o),
        .ovf_evt_o    (ovf_evt),
        .proto_evt_o  (proto_evt),
        .bna_set_o    (bna_set)
    );

    twa_lock u_lock (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ovf_evt_i   (ovf_evt),
        .proto_evt_i (proto_evt),
        .bna_set_i   (bna_set),
        .space_ok_i  (space_ok),
        .status_rd_i (status_rd_i),
        .resume_i    (resume_i),
        .ovf_o       (ovf_err_o),
        .proto_o     (proto_err_o),
        .buf_na_o    (buf_na_o),
        .locked_o    (locked)
    );

    always_comb rx_dma_req_o = dma_en_i && (rx_level_i >= rxbuf_thld_i);

    p_flags_after_reset_r11: assert property (@(posedge clk_i)
        !rst_ni |=> !(ovf_err_o || proto_err_o || buf_na_o));

endmodule

// File: tb/twa_ctrl_tb.sv
`timescale 1ns/1ps
module twa_ctrl_tb_top;
    localparam int DEPTH = 8;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 0, bvld = 0, perr = 0, rpush = 0, xend = 0, rfull = 0;
    logic dma_en = 0, srd = 0, resume = 0;
    logic [1:0] kind = 0;
    logic [CW-1:0] free = 8, level = 0, sthld = 4, bthld = 5;
    logic ack, nack, drop, ovf, proto, bna, dreq;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    twa_ctrl #(.FIFO_DEPTH(DEPTH)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .xfer_start_i(start), .xfer_kind_i(kind),
        .byte_vld_i(bvld), .parity_err_i(perr), .rsp_push_i(rpush),
        .xfer_end_i(xend), .rx_free_i(free), .rx_level_i(level),
        .rspq_full_i(rfull), .start_thld_i(sthld), .rxbuf_thld_i(bthld),
        .dma_en_i(dma_en), .status_rd_i(srd), .resume_i(resume),
        .ack_o(ack), .nack_o(nack), .drop_o(drop), .ovf_err_o(ovf),
        .proto_err_o(proto), .buf_na_o(bna), .rx_dma_req_o(dreq)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // start a transfer; after return, the decision cycle is visible
    task automatic begin_xfer(input logic [1:0] k);
        kind = k; start = 1; tick(); start = 0;
    endtask

    task automatic end_xfer();
        xend = 1; tick(); xend = 0;
    endtask

    task automatic recover();
        srd = 1; tick(); srd = 0;
        resume = 1; tick(); resume = 0;
    endtask

    task automatic t_reset();
        chk("R11", "ack", ack, 0);  chk("R11", "nack", nack, 0);
        chk("R11", "drop", drop, 0); chk("R11", "ovf", ovf, 0);
        chk("R11", "proto", proto, 0); chk("R11", "bna", bna, 0);
    endtask

    task automatic t_private_ok();
        free = 4; begin_xfer(2'd0);
        chk("R1", "ack at threshold", ack, 1); chk("R1", "nack", nack, 0);
        chk("R1", "drop", drop, 0);
        tick(); chk("R1", "ack is a pulse", ack, 0);
        end_xfer();
        free = 8; begin_xfer(2'd1);
        chk("R1", "directed ack", ack, 1);
        end_xfer();
    endtask

    task automatic t_space_nack();
        free = 3; begin_xfer(2'd0);
        chk("R1", "nack below threshold", nack, 1); chk("R1", "no ack", ack, 0);
        chk("R7", "bna set", bna, 1); chk("R1", "refused drops", drop, 1);
        tick(); chk("R7", "bna held while short", bna, 1);
        end_xfer(); chk("R1", "drop ends", drop, 0);
        free = 4; tick(); chk("R7", "bna auto clear", bna, 0);
    endtask

    task automatic t_rspq_nack();
        free = 8; rfull = 1; begin_xfer(2'd0);
        chk("R1", "nack on full queue", nack, 1); chk("R7", "no bna on queue full", bna, 0);
        rfull = 0; end_xfer();
    endtask

    task automatic t_overflow();
        free = 8; begin_xfer(2'd0); chk("R2", "ack", ack, 1);
        free = 0; bvld = 1; tick(); bvld = 0;
        chk("R2", "ovf set", ovf, 1); chk("R2", "drop after ovf", drop, 1);
        free = 8; bvld = 1; tick(); bvld = 0;
        chk("R2", "still dropping", drop, 1);
        end_xfer(); chk("R2", "drop cleared at end", drop, 0);
    endtask

    task automatic t_lockout();
        free = 8; begin_xfer(2'd0); chk("R5", "private nack while locked", nack, 1);
        end_xfer();
        begin_xfer(2'd1); chk("R5", "directed nack while locked", nack, 1);
        end_xfer();
        begin_xfer(2'd3); chk("R5", "reserved kind nack while locked", nack, 1);
        end_xfer();
        begin_xfer(2'd2); chk("R8", "broadcast ack while locked", ack, 1);
        chk("R8", "broadcast forwarded", drop, 0);
        end_xfer();
    endtask

    task automatic t_resume_order();
        resume = 1; tick(); resume = 0;
        chk("R6", "resume w/o read keeps ovf", ovf, 1);
        begin_xfer(2'd0); chk("R6", "still locked", nack, 1); end_xfer();
        recover();
        chk("R6", "ovf cleared", ovf, 0);
        begin_xfer(2'd0); chk("R6", "ack after recovery", ack, 1); end_xfer();
    endtask

    task automatic t_parity();
        begin_xfer(2'd0);
        bvld = 1; perr = 1; tick(); bvld = 0; perr = 0;
        chk("R3", "proto set", proto, 1); chk("R3", "ovf untouched", ovf, 0);
        chk("R3", "drop", drop, 1);
        end_xfer(); recover();
        chk("R3", "proto cleared", proto, 0);
    endtask

    task automatic t_both();
        begin_xfer(2'd0);
        free = 0; bvld = 1; perr = 1; tick(); bvld = 0; perr = 0; free = 8;
        chk("R10", "ovf", ovf, 1); chk("R10", "proto", proto, 1);
        end_xfer(); recover();
        chk("R10", "ovf cleared", ovf, 0); chk("R10", "proto cleared", proto, 0);
    endtask

    task automatic t_rsp_ovf();
        begin_xfer(2'd1); chk("R4", "ack", ack, 1);
        rfull = 1; rpush = 1; tick(); rpush = 0; rfull = 0;
        chk("R4", "ovf on queue overflow", ovf, 1); chk("R4", "drop", drop, 1);
        end_xfer();
        begin_xfer(2'd0); chk("R4", "locked after queue overflow", nack, 1); end_xfer();
        recover(); chk("R4", "cleared", ovf, 0);
    endtask

    task automatic t_rearm();
        begin_xfer(2'd0);
        bvld = 1; perr = 1; tick(); bvld = 0; perr = 0; end_xfer();
        srd = 1; tick(); srd = 0;
        // broadcast still admitted; new error after the read
        begin_xfer(2'd2);
        free = 0; bvld = 1; tick(); bvld = 0; free = 8; end_xfer();
        resume = 1; tick(); resume = 0;
        chk("R6", "new error needs fresh read (ovf)", ovf, 1);
        chk("R6", "new error needs fresh read (proto)", proto, 1);
        recover();
        chk("R6", "cleared after fresh read", ovf || proto, 0);
    endtask

    task automatic t_bcast_noroom();
        free = 1; begin_xfer(2'd2);
        chk("R8", "bcast ack no room", ack, 1); chk("R8", "bcast not forwarded", drop, 1);
        chk("R8", "no bna for bcast", bna, 0);
        end_xfer(); free = 8;
        rfull = 1; begin_xfer(2'd2); rfull = 0;
        chk("R8", "bcast ack queue full", ack, 1); chk("R8", "bcast dropped queue full", drop, 1);
        end_xfer();
    endtask

    task automatic t_dma();
        level = 7; dma_en = 0; #0.5; chk("R9", "disabled", dreq, 0);
        dma_en = 1; level = 5; #0.5; chk("R9", "at threshold", dreq, 1);
        level = 4; #0.5; chk("R9", "below threshold", dreq, 0);
        dma_en = 0; level = 0; tick();
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1; tick();
        t_reset();
        t_private_ok();
        t_space_nack();
        t_rspq_nack();
        t_overflow();
        t_lockout();
        t_resume_order();
        t_parity();
        t_both();
        t_rsp_ovf();
        t_rearm();
        t_bcast_noroom();
        t_dma();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule